// File: doc/BRIEF.md
# Banked GPIO Edge-Interrupt Controller

This block watches a vector of general-purpose input signals, arranged in banks of sixteen, and turns their edges into interrupt requests. Every input is brought into the module clock domain through a two-flop synchronizer. A rising or falling transition is then found by comparing the synchronized value with its value one clock earlier. Each input has its own rising-edge enable and falling-edge enable, so it can respond to rising edges only, falling edges only, both edges, or no edge.

Software drives a single-cycle register write port and reads through a combinational read port. The edge enables change only through paired write-one-to-set and write-one-to-clear locations, so no read-modify-write is needed. An enabled edge sets a sticky status bit, which stays set until software writes one to it.

A per-bank enable decides whether a bank's status reaches the outputs. The outputs are one interrupt line per input, one line per bank, and one OR-combined line.

Top module: `gpio_edge_irq`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all of the following are zero: rising enables, falling enables, bank enables, status, and every interrupt output.
- R2: A write to address 0 sets each rising-enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged. Reading address 0 or address 1 returns the rising-enable vector.
- R3: A write to address 1 clears each rising-enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R4: A write to address 2 sets falling-enable bits and a write to address 3 clears them, with the same write-one semantics as the rising pair. Reading address 2 or address 3 returns the falling-enable vector.
- R5: A rising edge on an input whose rising enable is set sets that input's status bit. The pin change is applied between two clock edges, and the status bit appears after the third clock edge that follows. It is not yet set after the second.
- R6: A falling edge sets the status bit only when the falling enable is set. With both enables set, either edge sets the status bit. With neither enable set, no edge sets it.
- R7: Reading address 5 returns the status vector. A write to address 5 clears each status bit whose data bit is 1, and data bits that are 0 leave their status bits unchanged.
- R8: If a newly detected edge and a write that clears the same status bit take effect on the same clock edge, the status bit ends up set.
- R9: Address 4 holds the bank-enable vector in its low bits, with bit n controlling bank n (inputs 16n to 16n+15). A read of address 4 returns it zero-extended. Reading address 6 or address 7 returns 0.
- R10: `bankIrq[n]` is the OR of bank n's status bits ANDed with bank-enable bit n. `pinIrq[i]` is status bit i ANDed with the enable of its bank. `irqAny` is the OR of all bank lines.
- R11: Status bits capture edges even while their bank is disabled. Enabling the bank afterwards raises that bank's interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| pinIn | input | NUM_BANKS*16 | Asynchronous general-purpose inputs |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | NUM_BANKS*16 | Write data |
| regRdData | output | NUM_BANKS*16 | Combinational read data for regAddr |
| pinIrq | output | NUM_BANKS*16 | Per-input interrupt lines |
| bankIrq | output | NUM_BANKS | Per-bank interrupt lines |
| irqAny | output | 1 | OR of all bank interrupt lines |

## Verification
The bench builds the block with its defaults: two banks of sixteen, which gives thirty-two inputs. This is small enough to sweep every input through all four edge modes, toggling the pin up and down and clearing the status afterwards, and to compare the status, every per-input line and both bank lines against a model built from bit arithmetic. Two banks are the fewest that show one bank's enable gating its own lines while leaving the other's alone. The same build covers the synchronizer latency window, the clash between an edge and a clearing write, and write-zero no-ops on every writable location.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;

  localparam logic [2:0] ADDR_RISE_SET = 3'd0;
  localparam logic [2:0] ADDR_RISE_CLR = 3'd1;
  localparam logic [2:0] ADDR_FALL_SET = 3'd2;
  localparam logic [2:0] ADDR_FALL_CLR = 3'd3;
  localparam logic [2:0] ADDR_BANK_EN  = 3'd4;
  localparam logic [2:0] ADDR_STATUS   = 3'd5;

  typedef struct packed {
    logic riseSet;
    logic riseClr;
    logic fallSet;
    logic fallClr;
    logic bankWr;
    logic statusClr;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    RD_RISE,
    RD_FALL,
    RD_BANK,
    RD_STATUS,
    RD_ZERO
  } rdSel_e;

endpackage

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
  import gpio_edge_irq_pkg::*;
(
  input  logic         regWrEn,
  input  logic [2:0]   regAddr,
  output ctrlStrobes_t strb,
  output rdSel_e       rdSel
);

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_RISE_SET: strb.riseSet   = 1'b1;
        ADDR_RISE_CLR: strb.riseClr   = 1'b1;
        ADDR_FALL_SET: strb.fallSet   = 1'b1;
        ADDR_FALL_CLR: strb.fallClr   = 1'b1;
        ADDR_BANK_EN:  strb.bankWr    = 1'b1;
        ADDR_STATUS:   strb.statusClr = 1'b1;
        default:       strb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_RISE_SET, ADDR_RISE_CLR: rdSel = RD_RISE;
      ADDR_FALL_SET, ADDR_FALL_CLR: rdSel = RD_FALL;
      ADDR_BANK_EN:                 rdSel = RD_BANK;
      ADDR_STATUS:                  rdSel = RD_STATUS;
      default:                      rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/gpio_edge_irq_datapath.sv
module gpio_edge_irq_datapath
  import gpio_edge_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_WIDTH  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS   = NUM_BANKS * BANK_WIDTH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  ctrlStrobes_t         strb,
  input  rdSel_e               rdSel,
  input  logic [NUM_PINS-1:0]  wrData,
  output logic [NUM_PINS-1:0]  rdData,
  output logic [NUM_PINS-1:0]  riseEnQ,
  output logic [NUM_PINS-1:0]  fallEnQ,
  output logic [NUM_BANKS-1:0] bankEnQ,
  output logic [NUM_PINS-1:0]  statusQ,
  output logic [NUM_PINS-1:0]  pinIrq,
  output logic [NUM_BANKS-1:0] bankIrq,
  output logic                 irqAny
);

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] syncedNow;
  logic [NUM_PINS-1:0] riseHit;
  logic [NUM_PINS-1:0] fallHit;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] statusNext;

  always_comb begin
    syncedNow  = syncQ[SYNC_STAGES-1];
    riseHit    = syncedNow & ~prevQ & riseEnQ;
    fallHit    = ~syncedNow & prevQ & fallEnQ;
    clrMask    = strb.statusClr ? wrData : '0;
    // a fresh edge wins over a clearing write on the same bit
    statusNext = (statusQ & ~clrMask) | riseHit | fallHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ   <= '0;
      prevQ   <= '0;
      riseEnQ <= '0;
      fallEnQ <= '0;
      bankEnQ <= '0;
      statusQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncedNow;
      if (strb.riseSet)      riseEnQ <= riseEnQ | wrData;
      else if (strb.riseClr) riseEnQ <= riseEnQ & ~wrData;
      if (strb.fallSet)      fallEnQ <= fallEnQ | wrData;
      else if (strb.fallClr) fallEnQ <= fallEnQ & ~wrData;
      if (strb.bankWr)       bankEnQ <= wrData[NUM_BANKS-1:0];
      statusQ <= statusNext;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign pinIrq[b*BANK_WIDTH +: BANK_WIDTH] =
      statusQ[b*BANK_WIDTH +: BANK_WIDTH] & {BANK_WIDTH{bankEnQ[b]}};
    assign bankIrq[b] = bankEnQ[b] & (|statusQ[b*BANK_WIDTH +: BANK_WIDTH]);
  end

  assign irqAny = |bankIrq;

  always_comb begin
    unique case (rdSel)
      RD_RISE:   rdData = riseEnQ;
      RD_FALL:   rdData = fallEnQ;
      RD_BANK:   rdData = {{(NUM_PINS-NUM_BANKS){1'b0}}, bankEnQ};
      RD_STATUS: rdData = statusQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_WIDTH  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS   = NUM_BANKS * BANK_WIDTH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  logic                 regWrEn,
  input  logic [2:0]           regAddr,
  input  logic [NUM_PINS-1:0]  regWrData,
  output logic [NUM_PINS-1:0]  regRdData,
  output logic [NUM_PINS-1:0]  pinIrq,
  output logic [NUM_BANKS-1:0] bankIrq,
  output logic                 irqAny
);

  ctrlStrobes_t          strb;
  rdSel_e                rdSel;
  logic [NUM_PINS-1:0]   riseEnVec;
  logic [NUM_PINS-1:0]   fallEnVec;
  logic [NUM_BANKS-1:0]  bankEnVec;
  logic [NUM_PINS-1:0]   statusVec;

  gpio_edge_irq_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  gpio_edge_irq_datapath #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK_WIDTH  (BANK_WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk     (clk),
    .rst     (rst),
    .pinIn   (pinIn),
    .strb    (strb),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .riseEnQ (riseEnVec),
    .fallEnQ (fallEnVec),
    .bankEnQ (bankEnVec),
    .statusQ (statusVec),
    .pinIrq  (pinIrq),
    .bankIrq (bankIrq),
    .irqAny  (irqAny)
  );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_PINS  = 32,
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 regWrEn,
  input logic [2:0]           regAddr,
  input logic [NUM_PINS-1:0]  regWrData,
  input logic [NUM_PINS-1:0]  riseEnVec,
  input logic [NUM_PINS-1:0]  fallEnVec,
  input logic [NUM_BANKS-1:0] bankEnVec,
  input logic [NUM_PINS-1:0]  statusVec,
  input logic [NUM_BANKS-1:0] bankIrq,
  input logic                 irqAny
);

  logic [NUM_PINS-1:0] clrMask;
  assign clrMask = (regWrEn && regAddr == 3'd5) ? regWrData : '0;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (statusVec == '0 && riseEnVec == '0 && fallEnVec == '0 && bankEnVec == '0));

  // R2
  rise_set_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 3'd0) |=> riseEnVec == ($past(riseEnVec) | $past(regWrData)));

  // R3
  rise_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 3'd1) |=> riseEnVec == ($past(riseEnVec) & ~$past(regWrData)));

  // R4
  fall_set_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 3'd2) |=> fallEnVec == ($past(fallEnVec) | $past(regWrData)));

  // R6
  status_cause_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusVec & ~$past(statusVec) & ~($past(riseEnVec) | $past(fallEnVec))) == '0));

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(statusVec) & ~$past(clrMask) & ~statusVec) == '0));

  // R10
  bank_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (bankIrq & ~bankEnVec) == '0);

  // R10
  irq_any_chk: assert property (@(posedge clk) disable iff (rst)
    irqAny == (bankIrq != '0));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NUM_PINS  (NUM_PINS),
  .NUM_BANKS (NUM_BANKS)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .riseEnVec (riseEnVec),
  .fallEnVec (fallEnVec),
  .bankEnVec (bankEnVec),
  .statusVec (statusVec),
  .bankIrq   (bankIrq),
  .irqAny    (irqAny)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  localparam int NB = 2;
  localparam int NP = NB * 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pinIn = '0;
  logic          regWrEn = 1'b0;
  logic [2:0]    regAddr = 3'd0;
  logic [NP-1:0] regWrData = '0;
  logic [NP-1:0] regRdData;
  logic [NP-1:0] pinIrq;
  logic [NB-1:0] bankIrq;
  logic          irqAny;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [NP-1:0] expRise = '0, expFall = '0, expStatus = '0;
  logic [NB-1:0] expBank = '0;

  always #10 clk = ~clk;

  gpio_edge_irq dut (
    .clk(clk), .rst(rst), .pinIn(pinIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIrq(pinIrq),
    .bankIrq(bankIrq), .irqAny(irqAny)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    case (a)
      3'd0: expRise = expRise | d;
      3'd1: expRise = expRise & ~d;
      3'd2: expFall = expFall | d;
      3'd3: expFall = expFall & ~d;
      3'd4: expBank = d[NB-1:0];
      3'd5: expStatus = expStatus & ~d;
      default: ;
    endcase
  endtask

  task automatic rdChk(input string tag, input logic [2:0] a, input logic [NP-1:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic outChk(input string tag);
    logic [NP-1:0] eb;
    logic [NP-1:0] ep;
    eb = '0;
    for (int b = 0; b < NB; b++) begin
      eb[b] = expBank[b] & (|expStatus[b*16 +: 16]);
      ep[b*16 +: 16] = expStatus[b*16 +: 16] & {16{expBank[b]}};
    end
    rdChk({tag, " status"}, 3'd5, expStatus);
    chk({tag, " pinIrq"}, pinIrq, ep);
    chk({tag, " bankIrq"}, NP'(bankIrq), eb);
    chk({tag, " irqAny"}, NP'(irqAny), NP'(|eb[NB-1:0]));
  endtask

  // drive pin at a falling clock edge, wait for the third rising edge
  task automatic setPin(input int i, input logic v);
    @(negedge clk);
    pinIn[i] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rdChk("R1 rise", 3'd0, '0);
    rdChk("R1 fall", 3'd2, '0);
    rdChk("R1 bank", 3'd4, '0);
    outChk("R1");

    // R9 bank enable and unused addresses
    wr(3'd4, NP'(2'b10));
    rdChk("R9 bank", 3'd4, NP'(2'b10));
    wr(3'd4, {NP{1'b1}});
    rdChk("R9 bank zero-extend", 3'd4, NP'(2'b11));
    rdChk("R9 addr6", 3'd6, '0);
    rdChk("R9 addr7", 3'd7, '0);

    // R2 R3 R4 write-one semantics, write-zero no effect
    wr(3'd0, 32'h0F0F_00FF);
    rdChk("R2 set", 3'd0, expRise);
    rdChk("R2 read via addr1", 3'd1, expRise);
    wr(3'd0, '0);
    rdChk("R2 zero write", 3'd0, 32'h0F0F_00FF);
    wr(3'd1, 32'h0000_000F);
    rdChk("R3 clear", 3'd0, 32'h0F0F_00F0);
    wr(3'd1, '0);
    rdChk("R3 zero write", 3'd0, 32'h0F0F_00F0);
    wr(3'd1, {NP{1'b1}});
    rdChk("R3 clear all", 3'd1, '0);
    wr(3'd2, 32'hA000_0005);
    rdChk("R4 set", 3'd2, 32'hA000_0005);
    wr(3'd3, 32'h2000_0001);
    rdChk("R4 clear", 3'd3, 32'h8000_0004);
    wr(3'd2, '0);
    wr(3'd3, '0);
    rdChk("R4 zero writes", 3'd2, 32'h8000_0004);
    wr(3'd3, {NP{1'b1}});
    rdChk("R4 clear all", 3'd2, '0);

    // R5 latency window on pin 3
    wr(3'd0, NP'(1) << 3);
    @(negedge clk);
    pinIn[3] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rdChk("R5 not yet after two edges", 3'd5, '0);
    @(posedge clk);
    @(negedge clk);
    expStatus[3] = 1'b1;
    outChk("R5 after third edge");
    setPin(3, 1'b0);
    outChk("R5 falling ignored when rise only");
    wr(3'd5, NP'(1) << 3);
    wr(3'd1, NP'(1) << 3);
    outChk("R7 cleared");

    // R5 R6 R7 R10 sweep: every pin, every edge mode
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 4; m++) begin
        if (m[0]) wr(3'd0, NP'(1) << i); else wr(3'd1, NP'(1) << i);
        if (m[1]) wr(3'd2, NP'(1) << i); else wr(3'd3, NP'(1) << i);
        setPin(i, 1'b1);
        if (m[0]) expStatus[i] = 1'b1;
        outChk("R5 R10 rising");
        setPin(i, 1'b0);
        if (m[1]) expStatus[i] = 1'b1;
        outChk("R6 R10 falling");
        wr(3'd5, '0);
        outChk("R7 zero write");
        wr(3'd5, NP'(1) << i);
        outChk("R7 w1c");
      end
      wr(3'd1, NP'(1) << i);
      wr(3'd3, NP'(1) << i);
    end

    // R8 edge and clear on the same clock edge
    wr(3'd0, NP'(1) << 7);
    wr(3'd2, NP'(1) << 7);
    setPin(7, 1'b1);
    expStatus[7] = 1'b1;
    outChk("R8 setup");
    @(negedge clk);
    pinIn[7] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd5; regWrData = NP'(1) << 7;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    outChk("R8 edge wins over clear");
    wr(3'd5, NP'(1) << 7);
    outChk("R8 later clear");

    // R11 capture while bank disabled
    wr(3'd4, '0);
    wr(3'd0, NP'(1) << 20);
    setPin(20, 1'b1);
    expStatus[20] = 1'b1;
    outChk("R11 bank off");
    wr(3'd4, NP'(2'b01));
    outChk("R11 other bank on");
    wr(3'd4, NP'(2'b10));
    outChk("R11 own bank on");

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    pinIn = '0;
    @(negedge clk);
    rst = 1'b0;
    expRise = '0; expFall = '0; expBank = '0; expStatus = '0;
    rdChk("R1 rise after reset", 3'd0, '0);
    rdChk("R1 fall after reset", 3'd3, '0);
    rdChk("R1 bank after reset", 3'd4, '0);
    outChk("R1 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule